// File: doc/BRIEF.md
# Four-Channel DAC Register Front End

This block sits between a simple 32-bit read/write register bus and the digital side of up to four 12-bit voltage DACs. Each channel owns a control register and a data register. Software writes a code into the data register and picks, through the control register, how the code reaches the converter. In core-paced mode the channel output latch reloads on every clock. In tick-paced mode it reloads only on a one-cycle timer tick. The control register also holds an active-low clear that forces the data register to zero, and a two-bit range field. Range code 00 powers the channel down and tristates its output.

Each channel is built around a four-state controller. Its state holds the clear bit and the pacing bit, so the state register is the stored copy of those two control bits:
- `ST_HOLD_CORE` (reset state): cleared, core-paced.
- `ST_HOLD_TICK`: cleared, tick-paced.
- `ST_RUN_CORE`: running, core-paced.
- `ST_RUN_TICK`: running, tick-paced.

Every control-register write is a transition. Its target is chosen by write data bit 4 (0 = HOLD, 1 = RUN) and bit 5 (0 = CORE, 1 = TICK). Any state can reach any other state in one write. With no control write, the state stays where it is. Reads are combinational: `rdata` is valid in the same cycle as `rd_en` and is zero when `rd_en` is low.

Top module: `dac_regbank`

## Requirements
- R1: After reset, every control and data register reads zero, every code output is zero, every range output is 00 and every tristate flag is 1.
- R2: Channel n has its control register at byte address 0x600+8n and its data register at 0x604+8n. The code sits in data bits 27:16. A written value reads back at the same address.
- R3: Control bits 31:6 and 3:2 read as zero, and so do data bits 31:28 and 15:0, whatever was written to them.
- R4: With control bit 5 = 0 (core-paced), the channel's code output equals its data register from the clock edge that writes the data register onward.
- R5: With control bit 5 = 1 (tick-paced), the code output holds its value while `tick` is low. It loads the data register at the clock edge where `tick` is high. If a data write and a tick arrive in the same cycle, the output loads the newly written code.
- R6: With control bit 4 = 0, the data register becomes zero at the clock edge after the control write. A bus write to the data register has no effect while the bit stays 0.
- R7: Control bits 1:0 drive the channel's range output. The encodings are 00 = power-down, 01 = external reference, 10 = internal reference and 11 = supply. The tristate flag is 1 exactly when the range is 00.
- R8: A read of any address that is not a mapped, word-aligned register returns zero. A write to such an address changes no register.
- R9: A write to one channel's register leaves every other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Byte address within the block window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| tick | input | 1 | One-cycle timer event |
| dac_code | output | 48 | Latched code, channel n in bits 12n+11:12n |
| dac_range | output | 8 | Range select, channel n in bits 2n+1:2n |
| dac_hiz | output | 4 | Power-down/tristate flag per channel |

## Verification
A controller left in the wrong state shows up on the next read of the control register, because bits 5 and 4 are decoded directly from the state. It also shows up at the code output within a cycle. In that case the output either follows a data write it should have held back until a tick, or stays frozen when it should follow. A clear that fails to take effect leaves a non-zero data readback one cycle after the clearing write. A decoder that selects the wrong channel changes a neighbouring channel's readback or code on the same edge as the write.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;

    // state encoding is {clear_n, tick_paced}
    typedef enum logic [1:0] {
        ST_HOLD_CORE = 2'b00,
        ST_HOLD_TICK = 2'b01,
        ST_RUN_CORE  = 2'b10,
        ST_RUN_TICK  = 2'b11
    } ch_state_e;

    localparam int CTRL_SRC_BIT  = 5;
    localparam int CTRL_CLRN_BIT = 4;
    localparam int REG_W         = 32;

endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode #(
    parameter int                NCH    = 4,
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE   = 'h600
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [NCH-1:0]    ctrl_wr,
    output logic [NCH-1:0]    data_wr,
    output logic [NCH-1:0]    ctrl_rd,
    output logic [NCH-1:0]    data_rd
);
    localparam int SPAN = NCH * 8;

    logic [ADDR_W-1:0] off;
    logic              in_win;

    assign off    = addr - BASE;
    assign in_win = (addr >= BASE) && (off < ADDR_W'(SPAN)) && (addr[1:0] == 2'b00);

    for (genvar n = 0; n < NCH; n++) begin : g_sel
        logic sel;
        assign sel        = in_win && (off[ADDR_W-1:3] == (ADDR_W-3)'(n));
        assign ctrl_wr[n] = sel && wr_en && !off[2];
        assign data_wr[n] = sel && wr_en &&  off[2];
        assign ctrl_rd[n] = sel && rd_en && !off[2];
        assign data_rd[n] = sel && rd_en &&  off[2];
    end
endmodule

// File: rtl/dac_channel.sv
module dac_channel
    import dac_regbank_pkg::*;
#(
    parameter int CODE_W   = 12,
    parameter int CODE_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              tick,
    output logic [REG_W-1:0]  ctrl_val,
    output logic [REG_W-1:0]  data_val,
    output logic [CODE_W-1:0] code_out,
    output logic [1:0]        range_out,
    output logic              hiz_out,
    output logic [1:0]        state_o,
    output logic [CODE_W-1:0] data_o
);
    ch_state_e         state, state_nx;
    logic [1:0]        range_q;
    logic [CODE_W-1:0] data_q, data_nx, out_q;
    logic              hold, tick_paced, load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOLD_CORE;
        else        state <= state_nx;
    end

    // transitions: every control write picks the target state
    always_comb begin
        state_nx = state;
        if (ctrl_wr) begin
            unique case ({wdata[CTRL_CLRN_BIT], wdata[CTRL_SRC_BIT]})
                2'b00: state_nx = ST_HOLD_CORE;
                2'b01: state_nx = ST_HOLD_TICK;
                2'b10: state_nx = ST_RUN_CORE;
                2'b11: state_nx = ST_RUN_TICK;
            endcase
        end
    end

    // outputs of the state
    always_comb begin
        unique case (state)
            ST_HOLD_CORE: begin hold = 1'b1; tick_paced = 1'b0; end
            ST_HOLD_TICK: begin hold = 1'b1; tick_paced = 1'b1; end
            ST_RUN_CORE:  begin hold = 1'b0; tick_paced = 1'b0; end
            ST_RUN_TICK:  begin hold = 1'b0; tick_paced = 1'b1; end
        endcase
    end

    always_comb begin
        if (hold)         data_nx = '0;
        else if (data_wr) data_nx = wdata[CODE_LSB +: CODE_W];
        else              data_nx = data_q;
        load = !tick_paced || tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= 2'b00;
            data_q  <= '0;
            out_q   <= '0;
        end else begin
            if (ctrl_wr) range_q <= wdata[1:0];
            data_q <= data_nx;
            if (load) out_q <= data_nx;
        end
    end

    always_comb begin
        ctrl_val                = '0;
        ctrl_val[CTRL_SRC_BIT]  = tick_paced;
        ctrl_val[CTRL_CLRN_BIT] = !hold;
        ctrl_val[1:0]           = range_q;
        data_val                = '0;
        data_val[CODE_LSB +: CODE_W] = data_q;
    end

    assign code_out  = out_q;
    assign range_out = range_q;
    assign hiz_out   = (range_q == 2'b00);
    assign state_o   = state;
    assign data_o    = data_q;
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CODE_W   = 12,
    parameter int CODE_LSB = 16,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic                  tick,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH*2-1:0]      dac_range,
    output logic [NCH-1:0]        dac_hiz
);
    logic [NCH-1:0]        ctrl_wr, data_wr, ctrl_rd, data_rd;
    logic [REG_W-1:0]      ctrl_val [NCH];
    logic [REG_W-1:0]      data_val [NCH];
    logic [2*NCH-1:0]      ch_state_flat;
    logic [NCH*CODE_W-1:0] ch_data_flat;

    dac_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(ADDR_W'('h600))) u_dec (
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .ctrl_wr(ctrl_wr), .data_wr(data_wr), .ctrl_rd(ctrl_rd), .data_rd(data_rd)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        dac_channel #(.CODE_W(CODE_W), .CODE_LSB(CODE_LSB)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctrl_wr(ctrl_wr[n]), .data_wr(data_wr[n]), .wdata(wdata), .tick(tick),
            .ctrl_val(ctrl_val[n]), .data_val(data_val[n]),
            .code_out(dac_code[n*CODE_W +: CODE_W]),
            .range_out(dac_range[2*n +: 2]),
            .hiz_out(dac_hiz[n]),
            .state_o(ch_state_flat[2*n +: 2]),
            .data_o(ch_data_flat[n*CODE_W +: CODE_W])
        );
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NCH; n++) begin
            if (ctrl_rd[n]) rdata = rdata | ctrl_val[n];
            if (data_rd[n]) rdata = rdata | data_val[n];
        end
    end
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [31:0]           rdata,
    input logic                  tick,
    input logic [2*NCH-1:0]      ch_state_flat,
    input logic [NCH*CODE_W-1:0] ch_data_flat,
    input logic [NCH*CODE_W-1:0] dac_code
);
    logic mapped;
    assign mapped = (addr >= ADDR_W'('h600)) && (addr < ADDR_W'('h600 + 8*NCH)) && (addr[1:0] == 2'b00);

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ((rdata & ~32'h0FFF_0033) == 32'h0));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |-> (rdata == 32'h0));

    for (genvar n = 0; n < NCH; n++) begin : g_p
        // R6
        hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_state_flat[2*n+1] |=> (ch_data_flat[n*CODE_W +: CODE_W] == '0));
        // R4
        core_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_state_flat[2*n] |=> (dac_code[n*CODE_W +: CODE_W] == ch_data_flat[n*CODE_W +: CODE_W]));
        // R5
        tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_state_flat[2*n] && !tick) |=> $stable(dac_code[n*CODE_W +: CODE_W]));
    end
endmodule

bind dac_regbank dac_regbank_chk #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata), .tick(tick),
    .ch_state_flat(ch_state_flat), .ch_data_flat(ch_data_flat), .dac_code(dac_code)
);

// File: tb/tb_dac_regbank.sv
`timescale 1ns/1ps
module tb_dac_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [47:0] dac_code;
    logic [7:0]  dac_range;
    logic [3:0]  dac_hiz;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    dac_regbank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick),
        .dac_code(dac_code), .dac_range(dac_range), .dac_hiz(dac_hiz)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    function automatic logic [31:0] code_of(input int ch);
        return {20'h0, dac_code[ch*12 +: 12]};
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            bus_rd(12'h600 + 12'(4*i), v);
            check("R1 reg after reset", v, 32'h0);
        end
        check("R1 code", {16'h0, dac_code[47:32]}, 32'h0);
        check("R1 code lo", dac_code[31:0], 32'h0);
        check("R1 range", {24'h0, dac_range}, 32'h0);
        check("R1 hiz", {28'h0, dac_hiz}, 32'hF);
    endtask

    task automatic t_map_core;
        logic [31:0] v;
        bus_wr(12'h610, 32'h11, 1'b0);
        bus_rd(12'h610, v);
        check("R2 ctrl ch2 readback", v, 32'h11);
        bus_wr(12'h614, 32'h0ABC_0000, 1'b0);
        bus_rd(12'h614, v);
        check("R2 data ch2 readback", v, 32'h0ABC_0000);
        check("R4 ch2 code follows", code_of(2), 32'hABC);
        bus_wr(12'h614, 32'h0123_0000, 1'b0);
        check("R4 ch2 code second write", code_of(2), 32'h123);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        bus_wr(12'h608, 32'hFFFF_FFFF, 1'b0);
        bus_rd(12'h608, v);
        check("R3 ctrl reserved", v, 32'h33);
        bus_wr(12'h60C, 32'hFFFF_FFFF, 1'b0);
        bus_rd(12'h60C, v);
        check("R3 data reserved", v, 32'h0FFF_0000);
    endtask

    task automatic t_timer;
        check("R5 ch1 holds before tick", code_of(1), 32'h0);
        idle(3);
        check("R5 ch1 still holds", code_of(1), 32'h0);
        pulse_tick;
        check("R5 ch1 loads on tick", code_of(1), 32'hFFF);
        bus_wr(12'h60C, 32'h0555_0000, 1'b0);
        check("R5 ch1 write without tick", code_of(1), 32'hFFF);
        bus_wr(12'h60C, 32'h0456_0000, 1'b1);
        check("R5 write and tick same cycle", code_of(1), 32'h456);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        bus_wr(12'h610, 32'h01, 1'b0);
        idle(1);
        bus_rd(12'h614, v);
        check("R6 data cleared", v, 32'h0);
        check("R6 ch2 code cleared", code_of(2), 32'h0);
        bus_wr(12'h614, 32'h0777_0000, 1'b0);
        bus_rd(12'h614, v);
        check("R6 write ignored while cleared", v, 32'h0);
        check("R6 code stays zero", code_of(2), 32'h0);
    endtask

    task automatic t_range;
        bus_wr(12'h618, 32'h12, 1'b0);
        check("R7 ch3 range 10", {30'h0, dac_range[7:6]}, 32'h2);
        check("R7 ch3 driven", {31'h0, dac_hiz[3]}, 32'h0);
        bus_wr(12'h618, 32'h10, 1'b0);
        check("R7 ch3 power-down", {31'h0, dac_hiz[3]}, 32'h1);
        check("R7 ch2 range 01", {30'h0, dac_range[5:4]}, 32'h1);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        bus_wr(12'h620, 32'hFFFF_FFFF, 1'b0);
        bus_wr(12'h5FC, 32'hFFFF_FFFF, 1'b0);
        bus_wr(12'h602, 32'hFFFF_FFFF, 1'b0);
        bus_wr(12'h606, 32'hFFFF_FFFF, 1'b0);
        bus_rd(12'h620, v); check("R8 read 0x620", v, 32'h0);
        bus_rd(12'h5FC, v); check("R8 read 0x5FC", v, 32'h0);
        bus_rd(12'h602, v); check("R8 read 0x602", v, 32'h0);
        bus_rd(12'h600, v); check("R8 ch0 ctrl untouched", v, 32'h0);
        bus_rd(12'h604, v); check("R8 ch0 data untouched", v, 32'h0);
        bus_rd(12'h618, v); check("R8 ch3 ctrl untouched", v, 32'h10);
    endtask

    task automatic t_independent;
        logic [31:0] v;
        bus_wr(12'h600, 32'h13, 1'b0);
        bus_wr(12'h604, 32'h0AAA_0000, 1'b0);
        check("R9 ch0 code", code_of(0), 32'hAAA);
        check("R9 ch1 code unchanged", code_of(1), 32'h456);
        check("R9 ch2 code unchanged", code_of(2), 32'h0);
        bus_rd(12'h60C, v); check("R9 ch1 data unchanged", v, 32'h0456_0000);
        bus_rd(12'h608, v); check("R9 ch1 ctrl unchanged", v, 32'h33);
        check("R9 ch0 range", {30'h0, dac_range[1:0]}, 32'h3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map_core;
        t_reserved;
        t_timer;
        t_clear;
        t_range;
        t_unmapped;
        t_independent;
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule